// File: doc/BRIEF.md
# Exponential Backoff Pause Timer

This block stalls one hardware thread after a failed atomic compare-and-swap attempt, so that other threads sharing the core can make progress. It holds a backoff count that begins at one and doubles on every accepted failure. The count stops growing once it has passed a fixed limit. Each accepted failure turns the count as it stood before doubling into a pause request worth 128 clock cycles per unit. The request is handed in one piece to a pause engine, which raises a stall output for that many cycles.

The pause engine loads the requested cycle amount divided by eight into a down-counter. It decrements that counter once every eight clocks through a prescaler, and the prescaler restarts from zero on every load. A request below eight cycles gives a stall of exactly one cycle. A trap input ends any pause at once. A raw pause value may also be written straight into the engine, which bypasses the backoff count. A start input or a success pulse returns the count to one and does not touch a pause that is already running.

The controller has three states. IDLE means no stall. SHORT is the single-cycle stall. PAUSE is the counted stall. The transitions are as follows:
- IDLE goes to SHORT on a load whose count is zero, and to PAUSE on a load whose count is non-zero.
- SHORT goes to IDLE when no load arrives. PAUSE goes to IDLE on the tick that takes the count from one to zero.
- Any state goes to IDLE on a trap.
- SHORT and PAUSE reload on a new write.

Top module: `exp_backoff_pause`

## Requirements
- R1: After reset, and in the cycle after a start pulse, the backoff value reads 1.
- R2: An accepted failure doubles the backoff value if it is at most 4096, and otherwise leaves it unchanged. The value never exceeds 8192.
- R3: An accepted failure with backoff value b raises stall from the next cycle for exactly b*128 consecutive cycles.
- R4: A raw write of value v with v >= 8 raises stall from the next cycle for exactly floor(v/8)*8 cycles.
- R5: A raw write of a value below 8, including 0, raises stall for exactly one cycle.
- R6: A trap ends any stall, so stall is low in the next cycle. A trap wins over a failure or a write in the same cycle.
- R7: A failure pulse while stall is high is ignored: the backoff value and the remaining stall do not change.
- R8: A success pulse sets the backoff value to 1 in the next cycle and leaves a running pause at its full length.
- R9: A raw write during a running pause restarts the pause from the new value, counted from the write.
- R10: A failure in the same cycle as start, success, write or trap is not accepted and starts no failure pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | New atomic sequence; backoff back to 1 |
| fail_i | input | 1 | Failed attempt pulse |
| succ_i | input | 1 | Successful attempt pulse |
| trap_i | input | 1 | Disrupting trap; aborts the pause |
| wr_en_i | input | 1 | Raw pause write strobe |
| wr_val_i | input | 21 | Raw pause amount in cycles |
| stall_o | output | 1 | Thread stalled |
| backoff_o | output | 14 | Current backoff count |

## Verification
A wrong backoff count shows on backoff_o in the cycle after the failure that produced it. It also shows later as a wrong stall length, in multiples of 128 cycles. A prescaler or down-counter fault changes the stall length by whole groups of eight cycles, so every pause is timed to the exact cycle. A wrongly accepted failure during a stall changes backoff_o one cycle later. It also lengthens the measured stall, which the bench reads only at the end of that pause.

// File: rtl/bo_pkg.sv
package bo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHORT = 2'd1,
        ST_PAUSE = 2'd2
    } pause_state_e;
endpackage

// File: rtl/bo_backoff_count.sv
module bo_backoff_count #(
    parameter int LIMIT = 4096,
    parameter int BO_W  = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            step,
    output logic [BO_W-1:0] q
);
    localparam logic [BO_W-1:0] LIM  = BO_W'(LIMIT);
    localparam logic [BO_W-1:0] ONE  = BO_W'(1);
    localparam logic [BO_W-1:0] CEIL = BO_W'(2 * LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= ONE;
        end else if (clear) begin
            q <= ONE;
        end else if (step && (q <= LIM)) begin
            q <= q << 1;
        end
    end

    // R1 / R8: clear brings the count back to one
    a_r1_clear_to_one: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (q == ONE));
    // R2: doubling below the limit
    a_r2_double: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && (q <= LIM)) |=> (q == ($past(q) << 1)));
    // R2: hold above the limit
    a_r2_hold_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && (q > LIM)) |=> $stable(q));
    // R2: ceiling
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (q <= CEIL) && (q != '0));
endmodule

// File: rtl/bo_tick_gen.sv
module bo_tick_gen #(
    parameter int GRAN_SHIFT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (GRAN_SHIFT > 0) ? GRAN_SHIFT : 1;
    localparam logic [PW-1:0] LAST = PW'((1 << GRAN_SHIFT) - 1);

    generate
        if (GRAN_SHIFT == 0) begin : g_every
            assign tick = run && !restart;
        end else begin : g_div
            logic [PW-1:0] pre;
            always_ff @(posedge clk) begin
                if (!rst_n || restart) begin
                    pre <= '0;
                end else if (run) begin
                    pre <= pre + PW'(1);
                end
            end
            assign tick = run && !restart && (pre == LAST);
        end
    endgenerate
endmodule

// File: rtl/bo_pause_ctl.sv
module bo_pause_ctl
    import bo_pkg::*;
#(
    parameter int PAUSE_W    = 21,
    parameter int GRAN_SHIFT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PAUSE_W-1:0] load_val,
    input  logic               abort,
    output logic               stall
);
    localparam int CNT_W = PAUSE_W - GRAN_SHIFT;
    localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

    pause_state_e state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_cnt;
    logic tick;
    logic run;

    assign load_cnt = load_val[PAUSE_W-1:GRAN_SHIFT];

    bo_tick_gen #(.GRAN_SHIFT(GRAN_SHIFT)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (load || abort),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (abort) begin
            state_nx = ST_IDLE;
        end else if (load) begin
            state_nx = (load_cnt == '0) ? ST_SHORT : ST_PAUSE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_SHORT: state_nx = ST_IDLE;
                ST_PAUSE: state_nx = (tick && (cnt == C_ONE)) ? ST_IDLE : ST_PAUSE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        stall = (state != ST_IDLE);
        run   = (state == ST_PAUSE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_cnt;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - C_ONE;
        end
    end

    // R6: abort returns to idle
    a_r6_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state == ST_IDLE));
    // R5: single-cycle stall leaves on its own
    a_r5_short_one: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SHORT) && !load) |=> (state == ST_IDLE));
    // R4: counter moves only on a prescaler tick
    a_r4_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PAUSE) && !tick && !load && !abort) |=> $stable(cnt));
    // R4: a counted pause never sits at zero
    a_r4_pause_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSE) |-> (cnt != '0));
endmodule

// File: rtl/exp_backoff_pause.sv
module exp_backoff_pause #(
    parameter int LIMIT      = 4096,
    parameter int UNIT_SHIFT = 7,
    parameter int GRAN_SHIFT = 3,
    parameter int BO_W       = $clog2(2 * LIMIT) + 1,
    parameter int PAUSE_W    = BO_W + UNIT_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               fail_i,
    input  logic               succ_i,
    input  logic               trap_i,
    input  logic               wr_en_i,
    input  logic [PAUSE_W-1:0] wr_val_i,
    output logic               stall_o,
    output logic [BO_W-1:0]    backoff_o
);
    logic               fail_acc;
    logic               load;
    logic [PAUSE_W-1:0] load_val;

    assign fail_acc = fail_i && !stall_o && !start_i && !succ_i && !wr_en_i && !trap_i;
    assign load     = wr_en_i || fail_acc;
    assign load_val = wr_en_i ? wr_val_i : (PAUSE_W'(backoff_o) << UNIT_SHIFT);

    bo_backoff_count #(.LIMIT(LIMIT), .BO_W(BO_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_i || succ_i),
        .step  (fail_acc),
        .q     (backoff_o)
    );

    bo_pause_ctl #(.PAUSE_W(PAUSE_W), .GRAN_SHIFT(GRAN_SHIFT)) u_pause (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .abort    (trap_i),
        .stall    (stall_o)
    );

    // R7: a stalled thread keeps its backoff unless cleared
    a_r7_fail_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !start_i && !succ_i) |=> $stable(backoff_o));
    // R6: trap drops stall in the next cycle
    a_r6_trap_stall: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i |=> !stall_o);
    // R3: an accepted failure stalls next cycle
    a_r3_fail_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        fail_acc |=> stall_o);
endmodule

// File: tb/tb_exp_backoff_pause.sv
module tb_exp_backoff_pause;
    localparam int CLK_PERIOD = 10;
    localparam int BO_W = 14;
    localparam int PW   = 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, fail_i = 0, succ_i = 0, trap_i = 0, wr_en_i = 0;
    logic [PW-1:0] wr_val_i = '0;
    logic stall_o;
    logic [BO_W-1:0] backoff_o;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    exp_backoff_pause dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fail_i(fail_i),
        .succ_i(succ_i), .trap_i(trap_i), .wr_en_i(wr_en_i),
        .wr_val_i(wr_val_i), .stall_o(stall_o), .backoff_o(backoff_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // kind: 0 none, 1 fail, 2 succ, 3 trap, 4 start, 5 write
    task automatic set_sig(input int kind, input logic v);
        case (kind)
            1: fail_i = v;
            2: succ_i = v;
            3: trap_i = v;
            4: start_i = v;
            5: wr_en_i = v;
            default: ;
        endcase
    endtask

    task automatic pulse(input int kind, input int val);
        @(negedge clk);
        wr_val_i = PW'(val);
        set_sig(kind, 1'b1);
        @(negedge clk);
        set_sig(kind, 1'b0);
    endtask

    // counts stall cycles; injects pulse 'kind' at stall cycle 'at'
    task automatic measure(input int kind, input int at, input int val, output int len);
        len = 0;
        while (stall_o && len < 70000) begin
            len++;
            if (len == at) begin
                wr_val_i = PW'(val);
                set_sig(kind, 1'b1);
            end
            @(negedge clk);
            set_sig(kind, 1'b0);
        end
    endtask

    task automatic t_reset();
        check("R1 reset backoff", int'(backoff_o), 1);
        check("R1 reset stall", int'(stall_o), 0);
    endtask

    task automatic t_fail_seq();
        int len;
        pulse(4, 0);
        check("R1 start", int'(backoff_o), 1);
        pulse(1, 0);
        check("R2 double to 2", int'(backoff_o), 2);
        measure(0, 0, 0, len);
        check("R3 pause b=1", len, 128);
        pulse(1, 0);
        measure(0, 0, 0, len);
        check("R3 pause b=2", len, 256);
        pulse(1, 0);
        measure(0, 0, 0, len);
        check("R3 pause b=4", len, 512);
        check("R2 value 8", int'(backoff_o), 8);
    endtask

    task automatic t_saturate();
        int exp_b = 1;
        pulse(4, 0);
        for (int i = 0; i < 15; i++) begin
            pulse(1, 0);
            exp_b = (exp_b <= 4096) ? exp_b * 2 : exp_b;
            check("R2 saturate step", int'(backoff_o), exp_b);
            pulse(3, 0);
            check("R6 trap clears stall", int'(stall_o), 0);
        end
        check("R2 ceiling 8192", int'(backoff_o), 8192);
    endtask

    task automatic t_raw();
        int len;
        pulse(5, 5);
        measure(0, 0, 0, len);
        check("R5 write 5", len, 1);
        pulse(5, 0);
        measure(0, 0, 0, len);
        check("R5 write 0", len, 1);
        pulse(5, 8);
        measure(0, 0, 0, len);
        check("R4 write 8", len, 8);
        pulse(5, 20);
        measure(0, 0, 0, len);
        check("R4 write 20", len, 16);
    endtask

    task automatic t_inject();
        int len;
        pulse(4, 0);
        pulse(1, 0);
        pulse(3, 0);
        pulse(1, 0);
        pulse(3, 0);
        check("R2 setup 4", int'(backoff_o), 4);
        pulse(5, 80);
        measure(1, 20, 0, len);
        check("R7 fail in stall length", len, 80);
        check("R7 fail in stall backoff", int'(backoff_o), 4);
        pulse(5, 80);
        measure(2, 20, 0, len);
        check("R8 success keeps pause", len, 80);
        check("R8 success backoff", int'(backoff_o), 1);
        pulse(5, 80);
        measure(3, 20, 0, len);
        check("R6 trap mid pause", len, 20);
        pulse(5, 80);
        measure(5, 20, 16, len);
        check("R9 rewrite restart", len, 36);
    endtask

    task automatic t_priority();
        @(negedge clk);
        fail_i = 1; succ_i = 1;
        @(negedge clk);
        fail_i = 0; succ_i = 0;
        check("R10 fail+succ no stall", int'(stall_o), 0);
        check("R10 fail+succ backoff", int'(backoff_o), 1);
        @(negedge clk);
        fail_i = 1; trap_i = 1;
        @(negedge clk);
        fail_i = 0; trap_i = 0;
        check("R10 fail+trap no stall", int'(stall_o), 0);
        check("R10 fail+trap backoff", int'(backoff_o), 1);
        @(negedge clk);
        wr_en_i = 1; trap_i = 1; wr_val_i = PW'(64);
        @(negedge clk);
        wr_en_i = 0; trap_i = 0;
        check("R6 trap beats write", int'(stall_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fail_seq();
        t_saturate();
        t_raw();
        t_inject();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule